// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Interrupts

This block is a parallel I/O port of up to 32 pins that a host reaches through a small word-addressed register bus. The bus has a write strobe, a read strobe, a two-bit word address and 32-bit write and read data. Each pin can be an input or an output. Output pins drive a value held in a data register and assert a per-pin output enable, so a tristate pad can be built outside the block. Input pins pass through a two-flop synchronizer before any logic uses them.

The port raises one interrupt line toward the host. Its trigger type is fixed for the whole port at build time. In the three edge types (rising, falling, both) a per-pin capture register records the selected edges, and software clears those bits by writing ones. In the level-high type the interrupt follows the synchronized input levels directly and the capture register stays empty. A mask register selects which pins may raise the interrupt.

Top module: `pio_port`

## Requirements
- R1: Registers sit at word address 0 (data), 1 (direction), 2 (interrupt mask) and 3 (edge capture), which are byte offsets 0x0, 0x4, 0x8 and 0xC. Read data is registered: it appears on `bus_rdata` in the cycle after `bus_rd` is sampled high and holds until the next read.
- R2: After reset the data, direction, mask and capture registers are zero, every `pin_oe` bit is 0 and `irq` is 0.
- R3: A direction bit of 1 makes that pin an output: `pin_oe` is 1 and `pin_out` carries the data register bit. A direction bit of 0 makes the pin an input with `pin_oe` at 0. A write to word 1 reaches `pin_oe` on the next clock edge.
- R4: A read of word 0 returns the data register bit for each output pin and the synchronized pin value for each input pin.
- R5: Register bits at or above `PIN_COUNT` cannot be set and read back as 0.
- R6: A pin change passes two flops before use: with the pin changed between edges, the synchronized value is not visible after the first following clock edge and is visible after the second.
- R7: In edge modes a capture bit sets when the synchronized pin shows the selected edge (0 to 1 for rising, 1 to 0 for falling, either for both); the bit is visible after the third clock edge following the pin change. The opposite edge in a single-edge mode sets nothing.
- R8: Writing 1 to a capture bit clears it; writing 0 leaves it unchanged.
- R9: When a new edge and a clearing write hit the same capture bit in the same cycle, the bit stays set.
- R10: In edge modes `irq` is 1 exactly when some capture bit and its mask bit are both 1; with the mask at zero `irq` stays 0.
- R11: In level-high mode `irq` is the OR of the synchronized inputs ANDed with the mask, and the capture register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin inputs |
| pin_out | output | PIN_COUNT | Values driven on output pins |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request to the host |

## Verification
The assertions assume the bus strobes and address are synchronous to `clk` and that write data is stable whenever `bus_wr` is high; the bench drives every bus signal on the falling edge and holds it over one rising edge. They also take `pin_in` to be asynchronous but only change the capture register through the synchronizer, so the bench changes pins on falling edges and lets at least one edge pass between changes when a check depends on exact latency. Pins are held low through reset so that no edge is seen as the synchronizer leaves reset.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int BUS_W    = 32;
    localparam int MAX_PINS = 32;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        IDX_DATA = 2'd0,
        IDX_DIR  = 2'd1,
        IDX_MASK = 2'd2,
        IDX_CAP  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic data;
        logic dir;
        logic mask;
        logic cap;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic wr, input logic [1:0] addr);
        wr_strobe_t s;
        s.data = wr && (reg_idx_e'(addr) == IDX_DATA);
        s.dir  = wr && (reg_idx_e'(addr) == IDX_DIR);
        s.mask = wr && (reg_idx_e'(addr) == IDX_MASK);
        s.cap  = wr && (reg_idx_e'(addr) == IDX_CAP);
        return s;
    endfunction

    function automatic logic [MAX_PINS-1:0] pick_edges(input trig_e mode,
                                                        input logic [MAX_PINS-1:0] cur,
                                                        input logic [MAX_PINS-1:0] prev);
        logic [MAX_PINS-1:0] e;
        case (mode)
            TRIG_RISE: e = cur & ~prev;
            TRIG_FALL: e = ~cur & prev;
            TRIG_BOTH: e = cur ^ prev;
            default:   e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    logic [N-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= pin_in;
            cur    <= meta_q;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/pio_ctrl_regs.sv
module pio_ctrl_regs
    import pio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_strobe_t   stb,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] out_q,
    output logic [N-1:0] dir_q,
    output logic [N-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            if (stb.data) out_q  <= wdata;
            if (stb.dir)  dir_q  <= wdata;
            if (stb.mask) mask_q <= wdata;
        end
    end
endmodule

// File: rtl/pio_capture.sv
module pio_capture
    import pio_pkg::*;
#(
    parameter int    N    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] cap_q,
    output logic [N-1:0] cap_set
);
    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            assign cap_set = '0;
            assign cap_q   = '0;
        end else begin : g_edge
            logic [MAX_PINS-1:0] cur_w, prev_w, hit_w;
            logic [N-1:0]        clr_eff;

            always_comb begin
                cur_w        = '0;
                prev_w       = '0;
                cur_w[N-1:0] = cur;
                prev_w[N-1:0] = prev;
                hit_w        = pick_edges(TRIG, cur_w, prev_w);
            end

            assign cap_set = hit_w[N-1:0];
            assign clr_eff = clr_en ? clr_bits : '0;

            always_ff @(posedge clk) begin
                if (rst) cap_q <= '0;
                else     cap_q <= (cap_q & ~clr_eff) | cap_set;
            end
        end
    endgenerate
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIG      = TRIG_RISE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [1:0]           bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);
    localparam int N = PIN_COUNT;

    wr_strobe_t   stb;
    logic [N-1:0] sync_cur, sync_prev;
    logic [N-1:0] out_q, dir_q, mask_q;
    logic [N-1:0] cap_q, cap_set;
    logic [N-1:0] data_view;
    logic [BUS_W-1:0] rd_next;

    assign stb = decode_write(bus_wr, bus_addr);

    pio_sync #(.N(N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .cur    (sync_cur),
        .prev   (sync_prev)
    );

    pio_ctrl_regs #(.N(N)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (bus_wdata[N-1:0]),
        .out_q  (out_q),
        .dir_q  (dir_q),
        .mask_q (mask_q)
    );

    pio_capture #(.N(N), .TRIG(TRIG)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cur      (sync_cur),
        .prev     (sync_prev),
        .clr_en   (stb.cap),
        .clr_bits (bus_wdata[N-1:0]),
        .cap_q    (cap_q),
        .cap_set  (cap_set)
    );

    assign data_view = (dir_q & out_q) | (~dir_q & sync_cur);

    always_comb begin
        rd_next = '0;
        case (reg_idx_e'(bus_addr))
            IDX_DATA: rd_next[N-1:0] = data_view;
            IDX_DIR:  rd_next[N-1:0] = dir_q;
            IDX_MASK: rd_next[N-1:0] = mask_q;
            default:  rd_next[N-1:0] = cap_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    generate
        if (TRIG == TRIG_LEVEL) begin : g_irq_level
            assign irq = |(sync_cur & mask_q);
        end else begin : g_irq_edge
            assign irq = |(cap_q & mask_q);
        end
    endgenerate
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
#(
    parameter int    N    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [N-1:0]     pin_oe,
    input logic             irq,
    input logic [N-1:0]     mask_q,
    input logic [N-1:0]     cap_q,
    input logic [N-1:0]     cap_set
);
    logic wr_cap, wr_dir;
    assign wr_cap = bus_wr && (bus_addr == 2'd3);
    assign wr_dir = bus_wr && (bus_addr == 2'd1);

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (pin_oe == $past(bus_wdata[N-1:0]))); // R3

    AST_CAP_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
        !wr_cap |=> ((cap_q & $past(cap_q)) == $past(cap_q))); // R8

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (wr_cap && (&bus_wdata[N-1:0]) && (cap_set == '0)) |=> (cap_q == '0)); // R8

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_cap && (cap_set != '0)) |=> ((cap_q & $past(cap_set)) == $past(cap_set))); // R9

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq); // R10

    AST_LEVEL_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (TRIG == TRIG_LEVEL) |-> (cap_q == '0)); // R11
endmodule

bind pio_port pio_port_chk #(.N(PIN_COUNT), .TRIG(TRIG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .mask_q    (mask_q),
    .cap_q     (cap_q),
    .cap_set   (cap_set)
);

// File: tb/sim_pio_port.sv
`timescale 1ns/1ps
module sim_pio_port;
    import pio_pkg::*;

    localparam int NP = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [NP-1:0] pins = '0;

    logic [31:0]   rd0, rd1, rd2, rd3;
    logic [NP-1:0] out0, out1, out2, out3;
    logic [NP-1:0] oe0, oe1, oe2, oe3;
    logic          irq0, irq1, irq2, irq3;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pio_port #(.PIN_COUNT(NP), .TRIG(TRIG_RISE)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .pin_in(pins), .pin_out(out0),
        .pin_oe(oe0), .irq(irq0));
    pio_port #(.PIN_COUNT(NP), .TRIG(TRIG_BOTH)) u1 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd1), .pin_in(pins), .pin_out(out1),
        .pin_oe(oe1), .irq(irq1));
    pio_port #(.PIN_COUNT(NP), .TRIG(TRIG_FALL)) u2 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd2), .pin_in(pins), .pin_out(out2),
        .pin_oe(oe2), .irq(irq2));
    pio_port #(.PIN_COUNT(NP), .TRIG(TRIG_LEVEL)) u3 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd3), .pin_in(pins), .pin_out(out3),
        .pin_oe(oe3), .irq(irq3));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic clear_all();
        idle(4);
        wr(2'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        chk("R2 oe after reset", 32'(oe0), 32'h0);
        chk("R2 irq after reset", {28'h0, irq0, irq1, irq2, irq3}, 32'h0);
        rd(2'd1); chk("R2 dir after reset", rd0, 32'h0);
        rd(2'd2); chk("R2 mask after reset", rd0, 32'h0);
        rd(2'd3); chk("R2 cap after reset", rd1, 32'h0);
        rd(2'd0); chk("R2 R1 data read after reset", rd0, 32'h0);
    endtask

    task automatic t_direction();
        wr(2'd1, 32'h0000_000F);
        chk("R3 oe follows direction", 32'(oe0), 32'h00F);
        wr(2'd0, 32'h0000_00A5);
        chk("R3 pin_out carries data", 32'(out0), 32'h0A5);
        set_pins(12'hF30);
        idle(3);
        rd(2'd0); chk("R4 mixed data read", rd0, 32'h0000_0F35);
        rd(2'd1); chk("R1 direction readback", rd0, 32'h0000_000F);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1); chk("R5 direction upper bits zero", rd0, 32'h0000_0FFF);
        rd(2'd0); chk("R4 all outputs ignore pins", rd0, 32'h0000_00A5);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2); chk("R5 mask upper bits zero", rd0, 32'h0000_0FFF);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0);
        chk("R3 oe cleared", 32'(oe0), 32'h0);
        set_pins('0);
        clear_all();
    endtask

    task automatic t_rise();
        set_pins(12'h001);
        idle(4);
        rd(2'd3);
        chk("R7 rising mode captures rise", rd0, 32'h1);
        chk("R7 both mode captures rise", rd1, 32'h1);
        chk("R7 falling mode ignores rise", rd2, 32'h0);
        chk("R11 level mode capture empty", rd3, 32'h0);
        chk("R10 masked capture gives no irq", {29'h0, irq0, irq1, irq2}, 32'h0);
        wr(2'd2, 32'h1);
        chk("R10 unmasked capture raises irq", {29'h0, irq0, irq1, irq2}, 32'h6);
        chk("R11 level irq with pin high", 32'(irq3), 32'h1);
        wr(2'd3, 32'h0);
        rd(2'd3); chk("R8 writing zero keeps capture", rd0, 32'h1);
        wr(2'd3, 32'h1);
        rd(2'd3); chk("R8 writing one clears capture", rd0, 32'h0);
        chk("R10 irq drops after clear", {30'h0, irq0, irq1}, 32'h0);
    endtask

    task automatic t_fall();
        set_pins(12'h000);
        idle(4);
        rd(2'd3);
        chk("R7 rising mode ignores fall", rd0, 32'h0);
        chk("R7 both mode captures fall", rd1, 32'h1);
        chk("R7 falling mode captures fall", rd2, 32'h1);
        chk("R10 irq per mode after fall", {28'h0, irq0, irq1, irq2, irq3}, 32'h6);
        clear_all();
        wr(2'd2, 32'h0);
    endtask

    task automatic t_level();
        wr(2'd2, 32'h4);
        set_pins(12'h004);
        @(negedge clk);
        chk("R6 not visible after one edge", 32'(irq3), 32'h0);
        @(negedge clk);
        chk("R6 R11 level irq after two edges", 32'(irq3), 32'h1);
        wr(2'd2, 32'h0);
        chk("R11 level irq masked", 32'(irq3), 32'h0);
        set_pins('0);
        clear_all();
    endtask

    task automatic t_collide();
        set_pins(12'h002);
        idle(4);
        rd(2'd3); chk("R7 first rise on bit 1", rd0, 32'h2);
        set_pins(12'h000);
        idle(4);
        set_pins(12'h002);
        @(negedge clk);
        wr(2'd3, 32'h2);
        rd(2'd3);
        chk("R9 rising edge beats clear", rd0, 32'h2);
        chk("R9 both mode edge beats clear", rd1, 32'h2);
        chk("R8 falling mode cleared without edge", rd2, 32'h0);
        set_pins('0);
        clear_all();
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direction();
        t_rise();
        t_fall();
        t_level();
        t_collide();
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule